// File: doc/BRIEF.md
# Clock Frequency Selection Controller

This block chooses the frequency setting that a clock synthesizer runs at and signals every time that setting changes. At power-up it captures a 5-bit hardware strap code once, on the first clock in which the active-low power-good input is low. After that it selects the active setting from one of three sources: the captured strap code, a 5-bit software select code, or a programmed divider pair N/M. The output frequency in divider mode is G*(N+3)/(M+3), where the ratio code picks the gear constant G.

A configuration block supplies the override bit, the divider-enable bit, the software select code, and the N and M values with one write strobe each. A watchdog supplies a recovery request, a recovery-source bit and a recovery N/M pair. While recovery is active, configuration changes are ignored. The block presents the effective ratio code, the effective N and M, the N+3 and M+3 operands, a divider-mode flag, an invalid-ratio flag, and a one-cycle change event.

Top module: `freq_sel_ctrl`

## Requirements
- R1: On the first rising clock edge after reset at which `pwrgd_n` is low, `strap_code` is captured. Later values of `pwrgd_n` and `strap_code` have no effect. Reset clears the captured code to 0 and re-arms the capture.
- R2: When divider mode is off (`nm_mode`=0), `eff_code` is the captured strap code if `sw_override`=0 and `sw_code` if `sw_override`=1. `eff_n` and `eff_m` are 0 in this mode.
- R3: When `prog_en`=1 outside recovery, `nm_mode`=1 and `eff_n`/`eff_m` are the last N/M values written. `eff_code` is still chosen by `sw_override` as in R2. `n_plus3`=`eff_n`+3 and `m_plus3`=`eff_m`+3 at all times.
- R4: Each accepted write (`n_wr` or `m_wr` high at a clock edge outside recovery) raises `freq_evt` for exactly one cycle after that edge. This holds even when the value written equals the old one, and even when divider mode is off.
- R5: `ratio_bad` is 1 exactly when `nm_mode`=1 and `n_plus3` <= `m_plus3`.
- R6: While `rec_active`=1 and `rec_sel`=0, `eff_code` is the captured strap code and `nm_mode`=0. While `rec_active`=1 and `rec_sel`=1, `nm_mode`=1 and `eff_n`/`eff_m` are `rec_n`/`rec_m`. In that case `eff_code` follows the override value held from before recovery.
- R7: While `rec_active`=1, N/M writes and changes of `sw_code`, `sw_override` and `prog_en` are ignored. After recovery ends, the current field values take effect and the N/M registers still hold their pre-recovery contents.
- R8: `freq_evt` is raised for one cycle whenever the tuple {`eff_code`, `eff_n`, `eff_m`, `nm_mode`} changes, including source switches with no write. It stays 0 while nothing changes and no write is accepted.
- R9: After reset with `pwrgd_n` high, `eff_code`=0, `eff_n`=0, `eff_m`=0, `nm_mode`=0, `ratio_bad`=0 and `freq_evt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Active-low power-good strobe |
| strap_code | input | 5 | Hardware strap frequency code |
| sw_code | input | 5 | Software frequency select code |
| sw_override | input | 1 | 1 = software code sets ratio, 0 = strap code |
| prog_en | input | 1 | Enables programmed N/M divider mode |
| n_val | input | 8 | N value to write |
| n_wr | input | 1 | N write strobe |
| m_val | input | 7 | M value to write |
| m_wr | input | 1 | M write strobe |
| rec_active | input | 1 | Watchdog recovery request |
| rec_sel | input | 1 | Recovery source: 0 strap code, 1 recovery N/M |
| rec_n | input | 8 | Recovery N value |
| rec_m | input | 7 | Recovery M value |
| eff_code | output | 5 | Effective ratio code |
| eff_n | output | 8 | Effective N (0 outside divider mode) |
| eff_m | output | 7 | Effective M (0 outside divider mode) |
| n_plus3 | output | 9 | eff_n + 3 |
| m_plus3 | output | 8 | eff_m + 3 |
| nm_mode | output | 1 | Divider mode in use |
| ratio_bad | output | 1 | Divider ratio not greater than 1 |
| freq_evt | output | 1 | One-cycle frequency-change event |

## Verification
The hardest situation to reach is a write attempted during recovery, because the effect of ignoring it is hidden until recovery ends. The bench first programs N/M, enters recovery, and then issues writes and changes the software fields while recovery is active. It checks that no event appears during this time. It then restores the fields and leaves recovery, and checks that the old N/M values come back unchanged. Rewriting an N value with the same value also needs a directed step, because only the write strobe, not any visible change, produces the event.

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl #(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int OFS    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrgd_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              sw_override,
  input  logic              prog_en,
  input  logic [N_W-1:0]    n_val,
  input  logic              n_wr,
  input  logic [M_W-1:0]    m_val,
  input  logic              m_wr,
  input  logic              rec_active,
  input  logic              rec_sel,
  input  logic [N_W-1:0]    rec_n,
  input  logic [M_W-1:0]    rec_m,
  output logic [CODE_W-1:0] eff_code,
  output logic [N_W-1:0]    eff_n,
  output logic [M_W-1:0]    eff_m,
  output logic [N_W:0]      n_plus3,
  output logic [M_W:0]      m_plus3,
  output logic              nm_mode,
  output logic              ratio_bad,
  output logic              freq_evt
);
  localparam int TUP_W = CODE_W + N_W + M_W + 1;

  logic              armed, locked;
  logic [CODE_W-1:0] strap_q, sel_q;
  logic              ovr_q, prog_q;
  logic [N_W-1:0]    n_q, rn_q;
  logic [M_W-1:0]    m_q, rm_q;
  logic              rec_q, rsel_q;
  logic              wr_seen;
  logic [TUP_W-1:0]  prev_tup;
  logic              accept_wr;

  assign accept_wr = (n_wr | m_wr) & ~rec_active;
  assign locked    = ~armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b1;
      strap_q <= '0;
    end else if (armed && !pwrgd_n) begin
      armed   <= 1'b0;
      strap_q <= strap_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ovr_q  <= 1'b0;
      prog_q <= 1'b0;
      n_q    <= '0;
      m_q    <= '0;
    end else if (!rec_active) begin
      sel_q  <= sw_code;
      ovr_q  <= sw_override;
      prog_q <= prog_en;
      if (n_wr) n_q <= n_val;
      if (m_wr) m_q <= m_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= 1'b0;
      rsel_q <= 1'b0;
      rn_q   <= '0;
      rm_q   <= '0;
    end else begin
      rec_q  <= rec_active;
      rsel_q <= rec_sel;
      rn_q   <= rec_n;
      rm_q   <= rec_m;
    end
  end

  always_comb begin
    eff_code = ovr_q ? sel_q : strap_q;
    nm_mode  = prog_q;
    eff_n    = prog_q ? n_q : '0;
    eff_m    = prog_q ? m_q : '0;
    if (rec_q) begin
      nm_mode = rsel_q;
      if (rsel_q) begin
        eff_n = rn_q;
        eff_m = rm_q;
      end else begin
        eff_code = strap_q;
        eff_n    = '0;
        eff_m    = '0;
      end
    end
  end

  assign n_plus3   = {1'b0, eff_n} + (N_W+1)'(OFS);
  assign m_plus3   = {1'b0, eff_m} + (M_W+1)'(OFS);
  assign ratio_bad = nm_mode & ({1'b0, m_plus3} >= n_plus3);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen  <= 1'b0;
      prev_tup <= '0;
    end else begin
      wr_seen  <= accept_wr;
      prev_tup <= {eff_code, eff_n, eff_m, nm_mode};
    end
  end

  assign freq_evt = wr_seen | (prev_tup != {eff_code, eff_n, eff_m, nm_mode});

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(strap_q));
  p_table_nm_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !nm_mode |-> (eff_n == '0 && eff_m == '0));
  p_wr_event_r4: assert property (@(posedge clk) disable iff (rst)
    accept_wr |=> freq_evt);
  p_bad_needs_mode_r5: assert property (@(posedge clk) disable iff (rst)
    ratio_bad |-> nm_mode);
  p_rec_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    rec_active |=> ($stable(n_q) && $stable(m_q) && $stable(ovr_q)));
endmodule

// File: tb/tb_freq_sel_ctrl.sv
module tb_freq_sel_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, pwrgd_n, sw_override, prog_en, n_wr, m_wr, rec_active, rec_sel;
  logic [4:0] strap_code, sw_code;
  logic [7:0] n_val, rec_n;
  logic [6:0] m_val, rec_m;
  logic [4:0] eff_code;
  logic [7:0] eff_n;
  logic [6:0] eff_m;
  logic [8:0] n_plus3;
  logic [7:0] m_plus3;
  logic       nm_mode, ratio_bad, freq_evt;

  freq_sel_ctrl dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // {ovr, prog, sel[4:0], n[7:0], m[6:0], exp_code[4:0], exp_mode, exp_bad}
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 1'b0, 5'h0A, 8'd100, 7'd45,  5'h13, 1'b0, 1'b0},
    {1'b1, 1'b0, 5'h0A, 8'd100, 7'd45,  5'h0A, 1'b0, 1'b0},
    {1'b1, 1'b1, 5'h1C, 8'd150, 7'd45,  5'h1C, 1'b1, 1'b0},
    {1'b0, 1'b1, 5'h1C, 8'd200, 7'd93,  5'h13, 1'b1, 1'b0},
    {1'b0, 1'b1, 5'h1C, 8'd40,  7'd40,  5'h13, 1'b1, 1'b1},
    {1'b0, 1'b1, 5'h1C, 8'd10,  7'd90,  5'h13, 1'b1, 1'b1},
    {1'b1, 1'b1, 5'h07, 8'd255, 7'd127, 5'h07, 1'b1, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; pwrgd_n = 1; strap_code = 5'h13; sw_code = 0; sw_override = 0;
    prog_en = 0; n_val = 0; m_val = 0; n_wr = 0; m_wr = 0;
    rec_active = 0; rec_sel = 0; rec_n = 0; rec_m = 0;
    repeat (3) tick();
    rst = 0;
    tick(); tick();
    chk("R9 code", eff_code, 0);
    chk("R9 mode", nm_mode, 0);
    chk("R9 evt", freq_evt, 0);
    chk("R9 n3", n_plus3, 3);
    chk("R9 bad", ratio_bad, 0);

    pwrgd_n = 0; tick();
    chk("R1 latch", eff_code, 5'h13);
    chk("R8 latch evt", freq_evt, 1);
    strap_code = 5'h05; pwrgd_n = 1; tick(); pwrgd_n = 0; tick(); tick();
    chk("R1 hold", eff_code, 5'h13);
    chk("R8 idle evt", freq_evt, 0);

    foreach (VEC[i]) begin
      logic [28:0] v;
      v = VEC[i];
      sw_override = v[28]; prog_en = v[27]; sw_code = v[26:22];
      n_val = v[21:14]; m_val = v[13:7]; n_wr = 1; m_wr = 1;
      tick();
      n_wr = 0; m_wr = 0;
      chk($sformatf("R2/R3 code v%0d", i), eff_code, v[6:2]);
      chk($sformatf("R3 mode v%0d", i), nm_mode, v[1]);
      chk($sformatf("R3 n v%0d", i), eff_n, v[1] ? v[21:14] : 0);
      chk($sformatf("R3 n3 v%0d", i), n_plus3, (v[1] ? v[21:14] : 0) + 3);
      chk($sformatf("R3 m3 v%0d", i), m_plus3, (v[1] ? v[13:7] : 0) + 3);
      chk($sformatf("R5 bad v%0d", i), ratio_bad, v[0]);
      chk($sformatf("R4 evt v%0d", i), freq_evt, 1);
      tick();
      chk($sformatf("R4 evt drop v%0d", i), freq_evt, 0);
    end

    // same-value rewrite, divider mode off
    prog_en = 0; sw_override = 1; sw_code = 5'h0A; tick(); tick();
    chk("R8 quiet", freq_evt, 0);
    n_val = 8'd255; n_wr = 1; tick(); n_wr = 0;
    chk("R4 same value evt", freq_evt, 1);
    chk("R2 n zero", eff_n, 0);
    tick();
    chk("R4 one cycle", freq_evt, 0);

    // source switch without write
    sw_override = 0; tick();
    chk("R8 switch code", eff_code, 5'h13);
    chk("R8 switch evt", freq_evt, 1);
    tick();
    chk("R8 switch drop", freq_evt, 0);

    // recovery
    sw_override = 1; sw_code = 5'h1C; prog_en = 1;
    n_val = 8'd150; m_val = 7'd45; n_wr = 1; m_wr = 1; tick();
    n_wr = 0; m_wr = 0; tick();
    chk("R3 pre-rec n", eff_n, 150);
    rec_active = 1; rec_sel = 0; tick();
    chk("R6 strap code", eff_code, 5'h13);
    chk("R6 strap mode", nm_mode, 0);
    chk("R6 enter evt", freq_evt, 1);
    n_val = 8'd60; n_wr = 1; sw_code = 5'h02; sw_override = 0; tick();
    n_wr = 0; tick();
    chk("R7 write ignored evt", freq_evt, 0);
    chk("R7 code held", eff_code, 5'h13);
    rec_sel = 1; rec_n = 8'd120; rec_m = 7'd93; tick();
    chk("R6 rec n", eff_n, 120);
    chk("R6 rec m", eff_m, 93);
    chk("R6 rec mode", nm_mode, 1);
    chk("R6 frozen ovr code", eff_code, 5'h1C);
    chk("R6 rec evt", freq_evt, 1);
    sw_code = 5'h1C; sw_override = 1; rec_active = 0; tick(); tick();
    chk("R7 n kept", eff_n, 150);
    chk("R7 m kept", eff_m, 45);
    chk("R7 code", eff_code, 5'h1C);

    // reset re-arms strap latch
    strap_code = 5'h09; rst = 1; tick();
    rst = 0; pwrgd_n = 1; sw_override = 0; prog_en = 0; tick();
    chk("R9 post reset code", eff_code, 0);
    pwrgd_n = 0; tick();
    chk("R1 rearm", eff_code, 5'h09);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule